// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the 8-bit status register that sits beside a small 8-bit ALU. It holds the carry, digit-carry and zero flags, the time-out and power-down bits, and a bank-select bit that picks which half of data memory direct addressing reaches. Every cycle it receives the class of the operation being executed, the two ALU operands, the ALU result, an optional software write with its data, and one-cycle strobes for power-on, watchdog clear, sleep and watchdog timeout.

The flag logic computes carry and digit carry itself from the operands. For subtraction these flags mean "no borrow". The zero flag comes from the result. An instruction can write this register and also update flags in the same cycle. In that case the flag logic owns all three of the zero, digit-carry and carry bits: the written data for those bits is dropped, and any flag the operation does not produce keeps its value. Time-out and power-down are never software writable. They are kept as a four-state machine with the states ST_RUN (time-out 1, power-down 1), ST_SLEPT (1,0), ST_TMO_RUN (0,1) and ST_TMO_SLEPT (0,0):

- Power-on and watchdog clear go to ST_RUN.
- Sleep goes to ST_SLEPT.
- Timeout goes from ST_RUN or ST_TMO_RUN to ST_TMO_RUN, and from ST_SLEPT or ST_TMO_SLEPT to ST_TMO_SLEPT.
- With no event, the state holds.

Top module: `aflag_status_reg`

## Requirements
- R1: While rst_n is low (asynchronous), rd_data reads 0x18: bits 7..5 = 0, time-out (bit 4) = 1, power-down (bit 3) = 1, Z (bit 2), DC (bit 1), C (bit 0) = 0; bank_sel = 0.
- R2: With op_cls = 0 (no flag update) and wr_en = 1, bits 7, 6, 5, 2, 1 and 0 take wr_data on the next clock edge; bank_sel always equals bit 5 (0 = addresses 00h-7Fh, 1 = 80h-FFh).
- R3: Bits 4 and 3 ignore wr_en and wr_data under every op_cls; they change only on power events.
- R4: When op_cls is nonzero, wr_data bits 2..0 are discarded while bits 7..5 are still written; flag bits the operation does not produce hold. A clear (wr_data = 0, op_cls = 1, alu_res = 0) leaves pattern 000u_u1uu.
- R5: op_cls = 2 (add): C = carry out of bit 7 of opa+opb, DC = carry out of bit 3, Z = (alu_res == 0).
- R6: op_cls = 3 (subtract opa-opb, done as opa + ~opb + 1): C = 1 when opa >= opb, DC = 1 when opa[3:0] >= opb[3:0], Z = (alu_res == 0).
- R7: op_cls = 4 (rotate left) loads C from opa[7]; op_cls = 5 (rotate right) loads C from opa[0]; Z and DC hold.
- R8: op_cls = 1 (zero-only class) sets Z = (alu_res == 0) and holds DC and C.
- R9: por or wdt_clr sets time-out and power-down to 1; sleep sets time-out 1 and power-down 0; wdt_to clears time-out and keeps power-down.
- R10: Power events in the same cycle resolve with priority por, then wdt_to, then wdt_clr, then sleep.
- R11: With op_cls = 0, wr_en = 0 and no power event, rd_data holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_cls | input | 3 | Operation class: 0 none, 1 zero-only, 2 add, 3 subtract, 4 rotate left, 5 rotate right |
| opa | input | 8 | First ALU operand (rotate source) |
| opb | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result |
| wr_en | input | 1 | Software write to this register |
| wr_data | input | 8 | Software write data |
| por | input | 1 | Power-on event strobe |
| wdt_clr | input | 1 | Watchdog clear event strobe |
| sleep | input | 1 | Sleep event strobe |
| wdt_to | input | 1 | Watchdog timeout event strobe |
| rd_data | output | 8 | Register read port |
| bank_sel | output | 1 | Data-memory bank select |

## Verification
The assertions assume that op_cls holds only the six defined codes and that alu_res is the value the ALU produced for the same operation. They also assume the event strobes follow the stated priority, with no other ordering rule. The bench drives only the encoded classes, changes every input on the falling edge, and keeps the power strobes low during the flag vectors. Same-cycle event combinations are raised only in the directed tests that check the priority.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
    localparam int DW  = 8;
    localparam int NIB = DW / 2;

    localparam int B_C    = 0;
    localparam int B_DC   = 1;
    localparam int B_Z    = 2;
    localparam int B_PD   = 3;
    localparam int B_TO   = 4;
    localparam int B_BANK = 5;
    localparam int HI_W   = DW - B_BANK;   // bank bit plus reserved bits
    localparam int FL_W   = 3;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_ZONLY = 3'd1,
        OPC_ADD   = 3'd2,
        OPC_SUB   = 3'd3,
        OPC_ROL   = 3'd4,
        OPC_ROR   = 3'd5
    } opc_e;

    // encoding is {time-out, power-down}
    typedef enum logic [1:0] {
        ST_RUN       = 2'b11,
        ST_SLEPT     = 2'b10,
        ST_TMO_RUN   = 2'b01,
        ST_TMO_SLEPT = 2'b00
    } pwr_st_e;
endpackage

// File: rtl/aflag_arith.sv
module aflag_arith
    import aflag_pkg::*;
#(
    parameter int W = DW,
    parameter int H = W / 2
) (
    input  logic [2:0]      opc,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    res,
    output logic [FL_W-1:0] val,   // {z, dc, c}
    output logic [FL_W-1:0] upd    // per-bit update mask
);
    logic [W:0] add_full, sub_full;
    logic [H:0] add_half, sub_half;
    logic       zr;

    always_comb begin
        add_full = {1'b0, a} + {1'b0, b};
        sub_full = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        add_half = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]};
        sub_half = {1'b0, a[H-1:0]} + {1'b0, ~b[H-1:0]} + (H+1)'(1);
        zr       = (res == '0);
    end

    always_comb begin
        val = '0;
        upd = '0;
        unique case (opc)
            OPC_ZONLY: begin
                val = {zr, 2'b00};
                upd = 3'b100;
            end
            OPC_ADD: begin
                val = {zr, add_half[H], add_full[W]};
                upd = 3'b111;
            end
            OPC_SUB: begin
                val = {zr, sub_half[H], sub_full[W]};
                upd = 3'b111;
            end
            OPC_ROL: begin
                val = {2'b00, a[W-1]};
                upd = 3'b001;
            end
            OPC_ROR: begin
                val = {2'b00, a[0]};
                upd = 3'b001;
            end
            default: begin
                val = '0;
                upd = '0;
            end
        endcase
    end
endmodule

// File: rtl/aflag_pwr_fsm.sv
module aflag_pwr_fsm
    import aflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_por,
    input  logic ev_clr,
    input  logic ev_sleep,
    input  logic ev_tmo,
    output logic to_bit,
    output logic pd_bit
);
    pwr_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (ev_por) begin
            st_d = ST_RUN;
        end else if (ev_tmo) begin
            unique case (st_q)
                ST_RUN, ST_TMO_RUN:     st_d = ST_TMO_RUN;
                ST_SLEPT, ST_TMO_SLEPT: st_d = ST_TMO_SLEPT;
                default:                st_d = ST_TMO_RUN;
            endcase
        end else if (ev_clr) begin
            st_d = ST_RUN;
        end else if (ev_sleep) begin
            st_d = ST_SLEPT;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_RUN:       begin to_bit = 1'b1; pd_bit = 1'b1; end
            ST_SLEPT:     begin to_bit = 1'b1; pd_bit = 1'b0; end
            ST_TMO_RUN:   begin to_bit = 1'b0; pd_bit = 1'b1; end
            ST_TMO_SLEPT: begin to_bit = 1'b0; pd_bit = 1'b0; end
            default:      begin to_bit = 1'b1; pd_bit = 1'b1; end
        endcase
    end
endmodule

// File: rtl/aflag_status_reg.sv
module aflag_status_reg
    import aflag_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_cls,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] alu_res,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          por,
    input  logic          wdt_clr,
    input  logic          sleep,
    input  logic          wdt_to,
    output logic [DW-1:0] rd_data,
    output logic          bank_sel
);
    logic [FL_W-1:0] fl_val, fl_upd, fl_q;
    logic [HI_W-1:0] hi_q;
    logic            to_b, pd_b;
    logic            sw_blocked;

    aflag_arith #(.W(DW), .H(NIB)) u_arith (
        .opc (op_cls),
        .a   (opa),
        .b   (opb),
        .res (alu_res),
        .val (fl_val),
        .upd (fl_upd)
    );

    aflag_pwr_fsm u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_por   (por),
        .ev_clr   (wdt_clr),
        .ev_sleep (sleep),
        .ev_tmo   (wdt_to),
        .to_bit   (to_b),
        .pd_bit   (pd_b)
    );

    // any flag-producing class takes the flag bits away from software
    assign sw_blocked = |fl_upd;

    genvar gi;
    generate
        for (gi = 0; gi < HI_W; gi++) begin : g_hi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     hi_q[gi] <= 1'b0;
                else if (wr_en) hi_q[gi] <= wr_data[B_BANK+gi];
            end
        end
        for (gi = 0; gi < FL_W; gi++) begin : g_fl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                     fl_q[gi] <= 1'b0;
                else if (fl_upd[gi])            fl_q[gi] <= fl_val[gi];
                else if (wr_en && !sw_blocked)  fl_q[gi] <= wr_data[B_C+gi];
            end
        end
    endgenerate

    assign rd_data  = {hi_q, to_b, pd_b, fl_q};
    assign bank_sel = hi_q[0];
endmodule

// File: rtl/aflag_status_chk.sv
module aflag_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_cls,
    input logic [7:0] opa,
    input logic [7:0] alu_res,
    input logic       wr_en,
    input logic       por,
    input logic       wdt_clr,
    input logic       sleep,
    input logic       wdt_to,
    input logic [7:0] rd_data
);
    AST_PWR_NO_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (!por && !wdt_clr && !sleep && !wdt_to) |=> $stable(rd_data[4:3])); // R3
    AST_SLEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !por && !wdt_clr && !wdt_to) |=> (rd_data[4:3] == 2'b10)); // R9
    AST_POR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> (rd_data[4:3] == 2'b11)); // R10
    AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_to && !por) |=> (!rd_data[4] && rd_data[3] == $past(rd_data[3]))); // R10
    AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd4) |=> (rd_data[0] == $past(opa[7]))); // R7
    AST_ROT_KEEP_ZDC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd4 || op_cls == 3'd5) |=> $stable(rd_data[2:1])); // R4
    AST_ZERO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd1 && alu_res == 8'h00) |=> rd_data[2]); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == 3'd0 && !wr_en) |=> $stable(rd_data[2:0])); // R11
endmodule

bind aflag_status_reg aflag_status_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_cls  (op_cls),
    .opa     (opa),
    .alu_res (alu_res),
    .wr_en   (wr_en),
    .por     (por),
    .wdt_clr (wdt_clr),
    .sleep   (sleep),
    .wdt_to  (wdt_to),
    .rd_data (rd_data)
);

// File: tb/aflag_status_reg_tb.sv
module aflag_status_reg_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 18;

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] r;
        logic       wr;
        logic [7:0] wd;
        logic [7:0] exp;
    } vec_t;

    // applied in order from the reset state 0x18; each row expects the full read value
    localparam vec_t VT [NV] = '{
        '{4'd2,  3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 8'hE7, 8'hFF}, // R2 R3 write, TO/PD ignore zeros
        '{4'd2,  3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 8'h18}, // R2
        '{4'd5,  3'd2, 8'h0F, 8'h01, 8'h10, 1'b0, 8'h00, 8'h1A}, // R5 digit carry only
        '{4'd5,  3'd2, 8'hFF, 8'h01, 8'h00, 1'b0, 8'h00, 8'h1F}, // R5 all flags
        '{4'd5,  3'd2, 8'h80, 8'h80, 8'h00, 1'b0, 8'h00, 8'h1D}, // R5 carry, no digit carry
        '{4'd6,  3'd3, 8'h05, 8'h03, 8'h02, 1'b0, 8'h00, 8'h1B}, // R6 no borrow
        '{4'd6,  3'd3, 8'h03, 8'h05, 8'hFE, 1'b0, 8'h00, 8'h18}, // R6 borrow
        '{4'd6,  3'd3, 8'h10, 8'h01, 8'h0F, 1'b0, 8'h00, 8'h19}, // R6 nibble borrow
        '{4'd6,  3'd3, 8'h42, 8'h42, 8'h00, 1'b0, 8'h00, 8'h1F}, // R6 equal
        '{4'd7,  3'd4, 8'h7F, 8'h00, 8'hFE, 1'b1, 8'hE0, 8'hFE}, // R7 R4 rotate left + write
        '{4'd7,  3'd5, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00, 8'hFF}, // R7 rotate right
        '{4'd4,  3'd1, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 8'h1F}, // R4 clear pattern
        '{4'd8,  3'd1, 8'h00, 8'h00, 8'h33, 1'b0, 8'h00, 8'h1B}, // R8 nonzero result
        '{4'd2,  3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h23, 8'h3B}, // R2
        '{4'd4,  3'd1, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 8'h1F}, // R4 clear keeps DC,C
        '{4'd11, 3'd0, 8'hAA, 8'h55, 8'h00, 1'b0, 8'h00, 8'h1F}, // R11 idle hold
        '{4'd4,  3'd2, 8'h01, 8'h01, 8'h02, 1'b1, 8'hC0, 8'hD8}, // R4 add + write
        '{4'd8,  3'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'hDC}  // R8 zero result
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_cls = '0;
    logic [7:0] opa = '0, opb = '0, alu_res = '0, wr_data = '0;
    logic       wr_en = 1'b0, por = 1'b0, wdt_clr = 1'b0, sleep = 1'b0, wdt_to = 1'b0;
    logic [7:0] rd_data;
    logic       bank_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    aflag_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .opa(opa), .opb(opb),
        .alu_res(alu_res), .wr_en(wr_en), .wr_data(wr_data), .por(por),
        .wdt_clr(wdt_clr), .sleep(sleep), .wdt_to(wdt_to),
        .rd_data(rd_data), .bank_sel(bank_sel)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        op_cls = '0; opa = '0; opb = '0; alu_res = '0; wr_en = 1'b0; wr_data = '0;
        por = 1'b0; wdt_clr = 1'b0; sleep = 1'b0; wdt_to = 1'b0;
    endtask

    // drive events after a falling edge, sample a quarter period after the next rising edge
    task automatic pwr(input logic p, input logic c, input logic s, input logic t,
                       input string tag, input logic [7:0] exp);
        @(negedge clk);
        quiet();
        por = p; wdt_clr = c; sleep = s; wdt_to = t;
        @(posedge clk);
        #(CLK_P/4);
        chk(tag, rd_data, exp);
    endtask

    task automatic swr(input logic [7:0] d, input string tag, input logic [7:0] exp);
        @(negedge clk);
        quiet();
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        #(CLK_P/4);
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(CLK_P*3);
        chk("R1 reset read", rd_data, 8'h18);
        chk("R1 reset bank", {7'b0, bank_sel}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            quiet();
            op_cls = VT[i].op; opa = VT[i].a; opb = VT[i].b; alu_res = VT[i].r;
            wr_en = VT[i].wr; wr_data = VT[i].wd;
            @(posedge clk);
            #(CLK_P/4);
            chk($sformatf("R%0d vector %0d", VT[i].req, i), rd_data, VT[i].exp);
            chk($sformatf("R2 bank vector %0d", i), {7'b0, bank_sel}, {7'b0, VT[i].exp[5]});
        end

        // state now 0xDC with time-out and power-down both 1
        pwr(1'b0, 1'b0, 1'b1, 1'b0, "R9 sleep", 8'hD4);
        pwr(1'b0, 1'b0, 1'b0, 1'b1, "R9 timeout", 8'hC4);
        swr(8'hFF, "R3 write ignored by TO/PD", 8'hE7);
        pwr(1'b0, 1'b1, 1'b0, 1'b0, "R9 watchdog clear", 8'hFF);
        pwr(1'b0, 1'b0, 1'b1, 1'b1, "R10 timeout over sleep", 8'hEF);
        pwr(1'b0, 1'b1, 1'b1, 1'b0, "R10 clear over sleep", 8'hFF);
        pwr(1'b0, 1'b0, 1'b1, 1'b0, "R9 sleep again", 8'hF7);
        pwr(1'b1, 1'b0, 1'b0, 1'b1, "R10 por over timeout", 8'hFF);
        pwr(1'b0, 1'b1, 1'b0, 1'b1, "R10 timeout over clear", 8'hEF);
        pwr(1'b1, 1'b0, 1'b0, 1'b0, "R9 power-on", 8'hFF);
        chk("R2 bank high", {7'b0, bank_sel}, 8'h01);
        swr(8'h00, "R2 clear write", 8'h18);
        chk("R2 bank low", {7'b0, bank_sel}, 8'h00);

        // idle cycle, then asynchronous reset from a non-reset state
        swr(8'hE5, "R2 write before reset", 8'hFD);
        pwr(1'b0, 1'b0, 1'b1, 1'b0, "R9 sleep before reset", 8'hF5);
        @(negedge clk);
        quiet();
        @(posedge clk);
        #(CLK_P/4);
        chk("R11 idle hold", rd_data, 8'hF5);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", rd_data, 8'h18);
        chk("R1 async reset bank", {7'b0, bank_sel}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule